// File: doc/BRIEF.md
# Optical-Black Offset Loop Controller

This block is the digital half of an offset-cancellation loop for an image-sensor front end. While the optical-black window strobe is high, each valid conversion code is compared against a programmable target. The block issues one up or down correction command per conversion to the offset DAC or charge pump that drives the analog integrator. Equal codes and cycles outside the window produce no command, so the analog side keeps its last value.

The block also chooses the loop gain. After every access on the serial port, the loop runs at high gain for a programmed number of black windows and then falls back to low gain. A separate configuration bit holds the gain high permanently. Four sources clear the loop state:

- the system reset;
- a black-level clear bit;
- a power-down bit;
- a low level on the standby pin.

Top module: `blk_loop_ctrl`

## Requirements
- R1: While any of `rst`, `blk_rst_cfg` or `pwr_dn_cfg` is high, or `stby_n` is low, the following cycle shows `corr_up`, `corr_dn`, `gain_high` and `boost_active` all low. The boost count is cleared.
- R2: When `ob_win` and `code_vld` are both high and `code_in` is below the target, `corr_up` is high and `corr_dn` is low in the next cycle.
- R3: When `ob_win` and `code_vld` are both high and `code_in` is above the target, `corr_dn` is high and `corr_up` is low in the next cycle.
- R4: When `ob_win` and `code_vld` are both high and `code_in` equals the target, both commands are low in the next cycle. The two commands are never high together.
- R5: When `ob_win` or `code_vld` is low, both commands are low in the next cycle, and the analog offset holds.
- R6: `target_cfg` is a 7-bit unsigned value, zero-extended and compared unsigned with the 10-bit code. Any code of 128 or more is above every target.
- R7: A serial access ends on a rising edge of `cs_n`. That edge loads the count with N = `boost_cfg[2:0]`. If N is nonzero, `gain_high` and `boost_active` are high from the next cycle.
- R8: Each falling edge of `ob_win` decrements a nonzero count. After N such edges, `boost_active` drops, and `gain_high` drops too unless forced.
- R9: An access with N = 0 leaves the gain low when `boost_cfg[3]` is 0.
- R10: While `boost_cfg[3]` is 1 and no clear is active, `gain_high` is high in the next cycle, whatever the count.
- R11: A new access during a count reloads the count to N, which restarts the window count.
- R12: When an access edge and a window falling edge happen in the same cycle, the reload wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_rst_cfg | input | 1 | Black-level clear configuration bit |
| pwr_dn_cfg | input | 1 | Power-down configuration bit |
| stby_n | input | 1 | Standby pin, low means powered down |
| code_in | input | 10 | Conversion code, straight binary |
| code_vld | input | 1 | Code valid this cycle |
| ob_win | input | 1 | Optical-black window strobe |
| cs_n | input | 1 | Serial-port chip select, active low |
| target_cfg | input | 7 | Target black code |
| boost_cfg | input | 4 | [3] force high gain, [2:0] boost window count |
| corr_up | output | 1 | Raise offset command |
| corr_dn | output | 1 | Lower offset command |
| gain_high | output | 1 | High loop gain select |
| boost_active | output | 1 | Boost count nonzero |

## Verification
Some properties can be checked on every cycle:

- the clear behaviour;
- mutual exclusion of the two commands;
- silence outside the window;
- the direction of each command against the target;
- the forced-gain bit;
- a boost that always implies high gain.

Other properties depend on history: the number of window edges a boost lasts, a restart by a second access, and the reload winning over a coincident window edge. Only the bench's reference model of the count can show these, over directed sequences and random traffic.

// File: rtl/blk_loop_pkg.sv
package blk_loop_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_UP   = 2'd1,
    CMD_DN   = 2'd2
  } corr_cmd_e;
endpackage

// File: rtl/blk_code_cmp.sv
module blk_code_cmp
  import blk_loop_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int TGT_W  = 7
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [TGT_W-1:0]  target,
  output logic              up,
  output logic              dn
);
  localparam int PAD_W = CODE_W - TGT_W;

  logic [CODE_W-1:0] tgt_ext;
  corr_cmd_e         cmd_d, cmd_q;

  assign tgt_ext = {{PAD_W{1'b0}}, target};

  always_comb begin
    cmd_d = CMD_HOLD;
    if (en) begin
      if (code < tgt_ext)      cmd_d = CMD_UP;
      else if (code > tgt_ext) cmd_d = CMD_DN;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) cmd_q <= CMD_HOLD;
    else     cmd_q <= cmd_d;
  end

  assign up = (cmd_q == CMD_UP);
  assign dn = (cmd_q == CMD_DN);
endmodule

// File: rtl/blk_edge_det.sv
module blk_edge_det #(
  parameter bit IDLE = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (clr) sig_q <= IDLE;
    else     sig_q <= sig;
  end

  assign rise = ~sig_q & sig;
  assign fall = sig_q & ~sig;
endmodule

// File: rtl/blk_boost_ctr.sv
module blk_boost_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] load_val,
  input  logic             force_hi,
  output logic             busy,
  output logic             gain_hi
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             gain_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                           cnt_d = load_val;
    else if (step && (cnt_q != '0))     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q  <= '0;
      gain_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      gain_q <= force_hi | (cnt_d != '0);
    end
  end

  assign busy    = (cnt_q != '0);
  assign gain_hi = gain_q;
endmodule

// File: rtl/blk_loop_ctrl.sv
module blk_loop_ctrl #(
  parameter int CODE_W  = 10,
  parameter int TGT_W   = 7,
  parameter int BOOST_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               blk_rst_cfg,
  input  logic               pwr_dn_cfg,
  input  logic               stby_n,
  input  logic [CODE_W-1:0]  code_in,
  input  logic               code_vld,
  input  logic               ob_win,
  input  logic               cs_n,
  input  logic [TGT_W-1:0]   target_cfg,
  input  logic [BOOST_W:0]   boost_cfg,
  output logic               corr_up,
  output logic               corr_dn,
  output logic               gain_high,
  output logic               boost_active
);
  logic loop_clr;
  logic acc_done, acc_start_unused;
  logic win_open_unused, win_close;

  assign loop_clr = rst | blk_rst_cfg | pwr_dn_cfg | ~stby_n;

  blk_code_cmp #(.CODE_W(CODE_W), .TGT_W(TGT_W)) u_cmp (
    .clk    (clk),
    .clr    (loop_clr),
    .en     (ob_win & code_vld),
    .code   (code_in),
    .target (target_cfg),
    .up     (corr_up),
    .dn     (corr_dn)
  );

  blk_edge_det #(.IDLE(1'b1)) u_cs_edge (
    .clk  (clk),
    .clr  (loop_clr),
    .sig  (cs_n),
    .rise (acc_done),
    .fall (acc_start_unused)
  );

  blk_edge_det #(.IDLE(1'b0)) u_ob_edge (
    .clk  (clk),
    .clr  (loop_clr),
    .sig  (ob_win),
    .rise (win_open_unused),
    .fall (win_close)
  );

  blk_boost_ctr #(.CNT_W(BOOST_W)) u_boost (
    .clk      (clk),
    .clr      (loop_clr),
    .load     (acc_done),
    .step     (win_close),
    .load_val (boost_cfg[BOOST_W-1:0]),
    .force_hi (boost_cfg[BOOST_W]),
    .busy     (boost_active),
    .gain_hi  (gain_high)
  );
endmodule

// File: rtl/blk_loop_chk.sv
module blk_loop_chk #(
  parameter int CODE_W  = 10,
  parameter int TGT_W   = 7,
  parameter int BOOST_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               blk_rst_cfg,
  input logic               pwr_dn_cfg,
  input logic               stby_n,
  input logic [CODE_W-1:0]  code_in,
  input logic               code_vld,
  input logic               ob_win,
  input logic               cs_n,
  input logic [TGT_W-1:0]   target_cfg,
  input logic [BOOST_W:0]   boost_cfg,
  input logic               corr_up,
  input logic               corr_dn,
  input logic               gain_high,
  input logic               boost_active
);
  logic              clr;
  logic [CODE_W-1:0] tgt;
  assign clr = rst | blk_rst_cfg | pwr_dn_cfg | ~stby_n;
  assign tgt = CODE_W'(target_cfg);

  a_r1_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!corr_up && !corr_dn && !gain_high && !boost_active));

  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(corr_up && corr_dn));

  a_r5_idle: assert property (@(posedge clk) disable iff (rst)
    (!clr && !(ob_win && code_vld)) |=> (!corr_up && !corr_dn));

  a_r2_up: assert property (@(posedge clk) disable iff (rst)
    (!clr && ob_win && code_vld && (code_in < tgt)) |=> corr_up);

  a_r3_down: assert property (@(posedge clk) disable iff (rst)
    (!clr && ob_win && code_vld && (code_in > tgt)) |=> corr_dn);

  a_r10_force: assert property (@(posedge clk) disable iff (rst)
    (!clr && boost_cfg[BOOST_W]) |=> gain_high);

  a_r8_busy_gain: assert property (@(posedge clk) disable iff (rst)
    boost_active |-> gain_high);
endmodule

bind blk_loop_ctrl blk_loop_chk #(
  .CODE_W(CODE_W), .TGT_W(TGT_W), .BOOST_W(BOOST_W)
) u_chk (
  .clk(clk), .rst(rst), .blk_rst_cfg(blk_rst_cfg), .pwr_dn_cfg(pwr_dn_cfg),
  .stby_n(stby_n), .code_in(code_in), .code_vld(code_vld), .ob_win(ob_win),
  .cs_n(cs_n), .target_cfg(target_cfg), .boost_cfg(boost_cfg),
  .corr_up(corr_up), .corr_dn(corr_dn), .gain_high(gain_high),
  .boost_active(boost_active)
);

// File: tb/tb_blk_loop_ctrl.sv
`timescale 1ns/1ps
module tb_blk_loop_ctrl;
  logic       clk = 1'b0;
  logic       rst, blk_rst_cfg, pwr_dn_cfg, stby_n;
  logic [9:0] code_in;
  logic       code_vld, ob_win, cs_n;
  logic [6:0] target_cfg;
  logic [3:0] boost_cfg;
  logic       corr_up, corr_dn, gain_high, boost_active;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  logic [2:0] m_cnt;
  logic       m_cs_q, m_ob_q;

  always #2.5 clk = ~clk;

  blk_loop_ctrl dut (
    .clk(clk), .rst(rst), .blk_rst_cfg(blk_rst_cfg), .pwr_dn_cfg(pwr_dn_cfg),
    .stby_n(stby_n), .code_in(code_in), .code_vld(code_vld), .ob_win(ob_win),
    .cs_n(cs_n), .target_cfg(target_cfg), .boost_cfg(boost_cfg),
    .corr_up(corr_up), .corr_dn(corr_dn), .gain_high(gain_high),
    .boost_active(boost_active)
  );

  task automatic check(input logic act, input logic exp, input string req,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string cmp_req(input logic clr, input logic en,
                                    input logic [9:0] c, input logic [6:0] t);
    if (clr)               return "R1";
    if (!en)               return "R5";
    if (c >= 10'd128)      return "R6";
    if (c < {3'b0, t})     return "R2";
    if (c > {3'b0, t})     return "R3";
    return "R4";
  endfunction

  task automatic tick();
    logic clr, en, e_up, e_dn, e_gain, e_busy;
    string rq;
    clr = rst | blk_rst_cfg | pwr_dn_cfg | ~stby_n;
    en  = ob_win & code_vld;
    rq  = cmp_req(clr, en, code_in, target_cfg);
    if (clr) begin
      e_up = 0; e_dn = 0; m_cnt = 0; m_cs_q = 1; m_ob_q = 0;
    end else begin
      e_up = en && (code_in < {3'b0, target_cfg});
      e_dn = en && (code_in > {3'b0, target_cfg});
      if (!m_cs_q && cs_n)                   m_cnt = boost_cfg[2:0];
      else if (m_ob_q && !ob_win && m_cnt != 0) m_cnt = m_cnt - 1;
      m_cs_q = cs_n; m_ob_q = ob_win;
    end
    e_busy = !clr && (m_cnt != 0);
    e_gain = !clr && (boost_cfg[3] || m_cnt != 0);
    @(posedge clk); #1;
    check(corr_up, e_up, rq, "corr_up");
    check(corr_dn, e_dn, rq, "corr_dn");
    check(gain_high, e_gain, clr ? "R1" : cur_req, "gain_high");
    check(boost_active, e_busy, clr ? "R1" : cur_req, "boost_active");
  endtask

  task automatic access();
    cs_n = 0; tick();
    cs_n = 1; tick();
  endtask

  task automatic ob_pulse();
    ob_win = 1; tick();
    ob_win = 0; tick();
  endtask

  task automatic compare(input logic [9:0] c, input logic [6:0] t);
    ob_win = 1; code_vld = 1; code_in = c; target_cfg = t; tick();
    ob_win = 0; code_vld = 0; tick();
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_cnt = 0; m_cs_q = 1; m_ob_q = 0;
    rst = 1; blk_rst_cfg = 0; pwr_dn_cfg = 0; stby_n = 1;
    code_in = 0; code_vld = 0; ob_win = 0; cs_n = 1;
    target_cfg = 7'd64; boost_cfg = 4'd0;
    // R1: reset state
    cur_req = "R1";
    repeat (3) tick();
    rst = 0; tick();

    // R2 R3 R4 R6: direction of correction
    compare(10'd10, 7'd64);
    compare(10'd100, 7'd64);
    compare(10'd64, 7'd64);
    compare(10'd128, 7'd127);
    compare(10'd1023, 7'd127);
    compare(10'd15, 7'd16);
    compare(10'd16, 7'd16);
    // R5: window closed or code invalid
    ob_win = 0; code_vld = 1; code_in = 10'd0; tick();
    ob_win = 1; code_vld = 0; tick();
    ob_win = 0; tick();

    // R7 R8: boost for 3 windows
    cur_req = "R7"; boost_cfg = 4'd3; access();
    cur_req = "R8"; repeat (4) ob_pulse();
    // R9: N of zero
    cur_req = "R9"; boost_cfg = 4'd0; access(); ob_pulse();
    // R10: forced high
    cur_req = "R10"; boost_cfg = 4'b1000; repeat (3) tick(); ob_pulse();
    boost_cfg = 4'b1010; access(); repeat (3) ob_pulse();
    // R11: restart mid-count
    cur_req = "R11"; boost_cfg = 4'd5; access(); ob_pulse(); ob_pulse();
    access(); repeat (6) ob_pulse();
    // R12: reload against coincident window close
    cur_req = "R12"; boost_cfg = 4'd2; access();
    ob_win = 1; cs_n = 0; tick();
    ob_win = 0; cs_n = 1; tick();
    repeat (3) ob_pulse();
    // R1: each clear source during a boost
    boost_cfg = 4'd7;
    access(); cur_req = "R1"; blk_rst_cfg = 1; tick(); blk_rst_cfg = 0; tick(); ob_pulse();
    access(); pwr_dn_cfg = 1; tick(); pwr_dn_cfg = 0; tick();
    access(); stby_n = 0; tick(); stby_n = 1; tick();
    access(); rst = 1; tick(); rst = 0; tick();

    // random traffic
    cur_req = "R8";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      code_in    = (r[3:0] == 0) ? {3'b0, target_cfg} : 10'($urandom);
      code_vld   = r[4] | r[5];
      ob_win     = (r[8:6] != 0) ? ob_win : ~ob_win;
      cs_n       = (r[12:9] == 0) ? ~cs_n : (r[13] ? 1'b1 : cs_n);
      if (r[20:14] == 0) boost_cfg = 4'($urandom);
      if (r[24:21] == 0) target_cfg = 7'($urandom);
      blk_rst_cfg = (r[31:25] == 0);
      pwr_dn_cfg  = (r[31:25] == 1);
      stby_n      = (r[31:25] != 2);
      rst         = (r[31:25] == 3);
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule